// File: doc/BRIEF.md
# Flag-Generating 16-bit Integer ALU

This block is the integer arithmetic and logic stage of a 16-bit microcontroller datapath. In one combinational pass it takes two operands, a four-bit operation code and a byte/word select. It returns a result and the set of five status flags that the operation leaves behind. The flags are carry (C), zero (Z), negative (N), signed overflow (OV) and digit carry (DC). A registered status word holds those flags between operations. The carry-in for add-with-carry, subtract-with-borrow and rotate-through-carry is taken from that register.

Each operation has a fixed mask that selects the flags it may change. Flags outside the mask keep their stored value. In byte mode only the low eight bits of each operand take part, and every flag is generated at the byte width. The upper byte of the result is operand A's upper byte, unchanged. Subtraction reports "no borrow" in C and DC: a 1 means the minuend was large enough.

Top module: `flag_alu`

## Requirements
- R1: ADD (op 0) returns A+B and ADDC (op 1) returns A+B+C, where C is sr_o bit 0. The carry out of the active width goes to flag bit 0 (C).
- R2: SUB (op 2) returns A-B and SUBB (op 3) returns A-B-(1-C). Both are computed as A + ~B + carry-in. C is 1 when no borrow occurs, and DC is 1 when no borrow occurs out of bit 3.
- R3: For ops 0-3, OV (flag bit 3) is set when the addends (A and B, or A and ~B for subtraction) share a sign and the result's sign differs from it. The sign is the top bit of the active width.
- R4: For ops 0-3, DC (flag bit 4) is the carry out of bit 3 of the same addition, in both widths.
- R5: Z (flag bit 1) is 1 when the active-width result is zero. N (flag bit 2) is the top bit of the active-width result.
- R6: With byte_i=1, only bits 7:0 are computed and flagged (C from bit 7, OV at 8 bits), and result_o[15:8] equals a_i[15:8].
- R7: AND (op 4), OR (op 5) and XOR (op 6) update only Z and N. C, OV and DC keep their stored values.
- R8: SHL (op 7), LSR (op 8), ASR (op 9) and RRC (op 10, which puts the stored C into the top bit) shift by one. The bit shifted out goes to C. They update C, Z and N only.
- R9: flags_o is the stored status with the operation's masked flags replaced. sr_o loads flags_o on a clock edge where valid_i=1 and holds otherwise.
- R10: Op codes 11-15 return a_i and leave every flag unchanged.
- R11: An asynchronous reset (rst_ni low) clears sr_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present; commits flags on the edge |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| a_i | input | 16 | Operand A (minuend, shifted operand) |
| b_i | input | 16 | Operand B |
| result_o | output | 16 | Combinational result |
| flags_o | output | 5 | Status after this operation {DC,OV,N,Z,C} |
| sr_o | output | 5 | Registered status {DC,OV,N,Z,C} |

## Verification
Properties are checked on every cycle for the following: the status register holds while no operation is valid, and logic operations preserve C, OV and DC in the register. Reserved codes pass A through and freeze the status. Subtracting equal word operands gives C=Z=DC=1 and OV=0. Adding zero is an identity that raises neither C nor OV. The carry of a left shift tracks the operand's top bit. Full numerical correctness needs the bench's sweep: the carry, digit carry and overflow values across sign and nibble boundaries, byte-mode upper-byte passthrough, and carry-in chaining from the previous operation. The sweep covers every op code in both widths over corner operands with both carry-in values.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 16;
  localparam int FLAG_W = 5;
  localparam int NIB_W  = 4;

  localparam int F_C  = 0;
  localparam int F_Z  = 1;
  localparam int F_N  = 2;
  localparam int F_OV = 3;
  localparam int F_DC = 4;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDC = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SUBB = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_SHL  = 4'd7;
  localparam logic [3:0] OP_LSR  = 4'd8;
  localparam logic [3:0] OP_ASR  = 4'd9;
  localparam logic [3:0] OP_RRC  = 4'd10;

  function automatic logic is_arith(input logic [3:0] op);
    return op <= OP_SUBB;
  endfunction

  function automatic logic is_logic(input logic [3:0] op);
    return (op >= OP_AND) && (op <= OP_XOR);
  endfunction

  function automatic logic is_shift(input logic [3:0] op);
    return (op >= OP_SHL) && (op <= OP_RRC);
  endfunction

  // flags an op may write, bit order {DC,OV,N,Z,C}
  function automatic logic [FLAG_W-1:0] flag_mask(input logic [3:0] op);
    if (is_arith(op)) return 5'b11111;
    if (is_logic(op)) return 5'b00110;
    if (is_shift(op)) return 5'b00111;
    return 5'b00000;
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  input  logic         byte_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         dc_o,
  output logic         ov_o
);
  localparam int HB = W / 2;

  logic         sub;
  logic         ci;
  logic [W-1:0] bx;
  logic [W:0]   full;
  logic [HB:0]  lo;
  logic [NIB_W:0] nib;
  logic         sa, sb, sr;

  always_comb begin
    sub = (op_i == OP_SUB) || (op_i == OP_SUBB);
    bx  = sub ? ~b_i : b_i;
    unique case (op_i)
      OP_ADD:  ci = 1'b0;
      OP_SUB:  ci = 1'b1;
      default: ci = cin_i;
    endcase
    full = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, ci};
    lo   = {1'b0, a_i[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, ci};
    nib  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, bx[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
    sum_o = full[W-1:0];
    c_o   = byte_i ? lo[HB] : full[W];
    dc_o  = nib[NIB_W];
    sa    = byte_i ? a_i[HB-1]  : a_i[W-1];
    sb    = byte_i ? bx[HB-1]   : bx[W-1];
    sr    = byte_i ? full[HB-1] : full[W-1];
    ov_o  = (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/alu_shlog.sv
module alu_shlog
  import alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  input  logic         byte_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         sc_o
);
  localparam int HB = W / 2;
  localparam logic [W-1:0] TOP_W = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] TOP_B = {{HB{1'b0}}, 1'b1, {(HB-1){1'b0}}};

  logic [W-1:0] w;
  logic [W-1:0] top;
  logic         msb;

  always_comb begin
    w   = byte_i ? {{HB{1'b0}}, a_i[HB-1:0]} : a_i;
    top = byte_i ? TOP_B : TOP_W;
    msb = byte_i ? a_i[HB-1] : a_i[W-1];
    res_o = a_i;
    sc_o  = cin_i;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_SHL: begin res_o = w << 1; sc_o = msb; end
      OP_LSR: begin res_o = w >> 1; sc_o = w[0]; end
      OP_ASR: begin res_o = (w >> 1) | (msb ? top : '0); sc_o = w[0]; end
      OP_RRC: begin res_o = (w >> 1) | (cin_i ? top : '0); sc_o = w[0]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_status.sv
module alu_status
  import alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [FLAG_W-1:0] mask_i,
  input  logic [FLAG_W-1:0] upd_i,
  output logic [FLAG_W-1:0] next_o,
  output logic [FLAG_W-1:0] sr_o
);
  logic [FLAG_W-1:0] sr_q;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_merge
    assign next_o[i] = mask_i[i] ? upd_i[i] : sr_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (valid_i) sr_q <= next_o;
  end

  assign sr_o = sr_q;

  // R9
  sr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sr_q));
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] sr_o
);
  localparam int HB = DATA_W / 2;

  logic [DATA_W-1:0] sum, shl_res, core;
  logic              as_c, as_dc, as_ov, sh_c;
  logic              z, n;
  logic [FLAG_W-1:0] upd;

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .byte_i(byte_i), .cin_i(sr_o[F_C]),
    .sum_o(sum), .c_o(as_c), .dc_o(as_dc), .ov_o(as_ov)
  );

  alu_shlog #(.W(DATA_W)) u_shlog (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .byte_i(byte_i), .cin_i(sr_o[F_C]),
    .res_o(shl_res), .sc_o(sh_c)
  );

  always_comb begin
    core = is_arith(op_i) ? sum : shl_res;
    z    = byte_i ? (core[HB-1:0] == '0) : (core == '0);
    n    = byte_i ? core[HB-1] : core[DATA_W-1];
    upd  = '0;
    upd[F_Z]  = z;
    upd[F_N]  = n;
    upd[F_C]  = is_arith(op_i) ? as_c : sh_c;
    upd[F_OV] = as_ov;
    upd[F_DC] = as_dc;
    if (!(is_arith(op_i) || is_logic(op_i) || is_shift(op_i))) result_o = a_i;
    else if (byte_i) result_o = {a_i[DATA_W-1:HB], core[HB-1:0]};
    else             result_o = core;
  end

  alu_status u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .mask_i(flag_mask(op_i)), .upd_i(upd), .next_o(flags_o), .sr_o(sr_o)
  );

  // R1
  add_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ADD && !byte_i && b_i == '0)
      |-> (result_o == a_i && !flags_o[F_C] && !flags_o[F_OV]));
  // R2
  sub_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SUB && !byte_i && a_i == b_i)
      |-> (flags_o[F_C] && flags_o[F_Z] && flags_o[F_DC] && !flags_o[F_OV]));
  // R8
  shl_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SHL)
      |-> (flags_o[F_C] == (byte_i ? a_i[HB-1] : a_i[DATA_W-1])));
  // R7
  logic_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= OP_AND && op_i <= OP_XOR)
      |=> (sr_o[F_C] == $past(sr_o[F_C]) && sr_o[F_OV] == $past(sr_o[F_OV])
           && sr_o[F_DC] == $past(sr_o[F_DC])));
  // R10
  rsv_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > OP_RRC) |=> $stable(sr_o));
  // R10
  rsv_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_RRC) |-> (result_o == a_i));
endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        byte_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [15:0] result_o;
  logic [4:0]  flags_o, sr_o;

  int errors = 0;
  int checks = 0;
  logic [4:0] exp_sr = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_alu uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .byte_i(byte_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .flags_o(flags_o), .sr_o(sr_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (op=%0d byte=%0b a=%h b=%h)",
               req, act, exp, op_i, byte_i, a_i, b_i);
    end
  endtask

  function automatic void model(input logic [3:0] op, input logic bm,
                                input logic [15:0] a, input logic [15:0] b,
                                input logic [4:0] old,
                                output logic [15:0] res, output logic [4:0] nf);
    int w, msk, aa, bb, bx, ci, s, r;
    logic c, z, n, ov, dc, cin;
    logic [4:0] um, nw;
    w = bm ? 8 : 16;
    msk = (1 << w) - 1;
    aa = int'(a) & msk;
    bb = int'(b) & msk;
    cin = old[0];
    c = cin; ov = old[3]; dc = old[4];
    r = aa; um = '0;
    case (op)
      0, 1, 2, 3: begin
        bx = (op >= 2) ? (~bb) & msk : bb;
        ci = (op == 0) ? 0 : (op == 2) ? 1 : int'(cin);
        s  = aa + bx + ci;
        r  = s & msk;
        c  = ((s >> w) & 1) != 0;
        dc = ((((aa & 15) + (bx & 15) + ci) >> 4) & 1) != 0;
        ov = (((aa >> (w-1)) & 1) == ((bx >> (w-1)) & 1)) &&
             (((r >> (w-1)) & 1) != ((aa >> (w-1)) & 1));
        um = 5'b11111;
      end
      4: begin r = aa & bb; um = 5'b00110; end
      5: begin r = aa | bb; um = 5'b00110; end
      6: begin r = aa ^ bb; um = 5'b00110; end
      7: begin c = ((aa >> (w-1)) & 1) != 0; r = (aa << 1) & msk; um = 5'b00111; end
      8: begin c = (aa & 1) != 0; r = aa >> 1; um = 5'b00111; end
      9: begin c = (aa & 1) != 0; r = (aa >> 1) | (aa & (1 << (w-1))); um = 5'b00111; end
      10: begin c = (aa & 1) != 0; r = (aa >> 1) | (int'(cin) << (w-1)); um = 5'b00111; end
      default: ;
    endcase
    if (op > 10) begin
      res = a; nf = old;
    end else begin
      z = (r == 0);
      n = ((r >> (w-1)) & 1) != 0;
      nw = {dc, ov, n, z, c};
      nf = (old & ~um) | (nw & um);
      res = bm ? {a[15:8], r[7:0]} : r[15:0];
    end
  endfunction

  function automatic string res_tag(input logic [3:0] op, input logic bm);
    string t;
    if (op <= 1)       t = "R1";
    else if (op <= 3)  t = "R2";
    else if (op <= 6)  t = "R7";
    else if (op <= 10) t = "R8";
    else               t = "R10";
    return bm ? {t, "/R6"} : t;
  endfunction

  function automatic string flag_tag(input logic [3:0] op);
    if (op <= 3)  return "R3/R4/R5";
    if (op <= 6)  return "R5/R7";
    if (op <= 10) return "R5/R8";
    return "R10";
  endfunction

  task automatic apply(input logic [3:0] op, input logic bm,
                       input logic [15:0] a, input logic [15:0] b);
    logic [15:0] er;
    logic [4:0]  ef;
    @(negedge clk);
    op_i = op; byte_i = bm; a_i = a; b_i = b; valid_i = 1'b1;
    model(op, bm, a, b, exp_sr, er, ef);
    #1;
    check(res_tag(op, bm), result_o, er);
    check(flag_tag(op), {11'd0, flags_o}, {11'd0, ef});
    @(posedge clk);
    #1;
    exp_sr = ef;
    check("R9", {11'd0, sr_o}, {11'd0, exp_sr});
  endtask

  task automatic idle(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    valid_i = 1'b0; op_i = op; a_i = a; b_i = b;
    @(posedge clk);
    #1;
    check("R9 hold", {11'd0, sr_o}, {11'd0, exp_sr});
  endtask

  initial begin
    logic [15:0] vals [10];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h000F; vals[3] = 16'h0010;
    vals[4] = 16'h007F; vals[5] = 16'h0080; vals[6] = 16'h00FF; vals[7] = 16'h7FFF;
    vals[8] = 16'h8000; vals[9] = 16'hFFFF;

    #(CLK_PERIOD*2 + 2);
    check("R11", {11'd0, sr_o}, 16'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check("R11", {11'd0, sr_o}, 16'd0);

    // R9: no update without valid_i
    apply(4'd2, 1'b0, 16'h0005, 16'h0005);
    idle(4'd0, 16'hFFFF, 16'h0001);
    idle(4'd7, 16'h8000, 16'h0000);
    apply(4'd0, 1'b0, 16'h0000, 16'h0000);
    idle(4'd2, 16'h0000, 16'h0001);

    for (int op = 0; op < 16; op++)
      for (int bm = 0; bm < 2; bm++)
        for (int i = 0; i < 10; i++)
          for (int j = 0; j < 10; j++)
            for (int ci = 0; ci < 2; ci++) begin
              apply(ci != 0 ? 4'd2 : 4'd0, 1'b0, 16'h0000, 16'h0000);
              apply(4'(op), bm != 0, vals[i], vals[j] ^ 16'(i << 8));
            end

    // R11: asynchronous reset mid-run
    apply(4'd2, 1'b0, 16'h0000, 16'h0000);
    @(negedge clk);
    valid_i = 1'b0;
    #2;
    rst_ni = 1'b0;
    #1;
    check("R11 async", {11'd0, sr_o}, 16'd0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule